// File: doc/BRIEF.md
# Exponential Retry Backoff Controller

This block paces retries of a contended compare-and-swap. It keeps a backoff count for the current atomic operation. Each failed attempt makes the requester wait before it tries again. The length of that wait comes from the count. After each wait is issued, the count doubles, up to a fixed ceiling. A successful attempt, or the start of a new operation, puts the count back to one.

The wait is not built from a loop of fixed-size pauses. It is one request to a downstream strand-pause unit, and that request carries the whole amount in cycles. The amount is the count shifted left by seven bits, so one unit of count is 128 cycles. The requester gets a one-cycle retry permit once the pause unit reports that the pause is over.

Top module: `retry_backoff_ctrl`

## Requirements
- R1: After synchronous active-low reset, `pause_req`, `retry_permit` and `pause_amt` are 0, and the backoff count is 1, so the first pause amount is 128.
- R2: A fail strobe taken while no pause is in progress raises `pause_req` for exactly one cycle, in the cycle after the strobe. In that cycle `pause_amt` equals the count multiplied by 128, which is the count shifted left by 7.
- R3: Each taken fail strobe doubles the count for the next request, so successive amounts are 128, 256, 512 and onward.
- R4: The count saturates at 4096. Once the count has reached 4096, every further request carries 524288 cycles.
- R5: A success strobe sets the count back to 1.
- R6: A new-operation strobe sets the count back to 1, and a fail strobe in the same cycle is ignored.
- R7: A fail strobe that arrives while a pause is in progress is ignored. It raises no request and does not double the count, and this also holds in the cycle where `pause_done` arrives.
- R8: `pause_done`, received while a pause is in progress, raises `retry_permit` for exactly one cycle, in the next cycle. `pause_done` received when no pause is in progress has no effect.
- R9: `pause_amt` keeps its value between requests.
- R10: When success and fail strobes arrive in the same cycle, the success wins: the count is set back to 1 and no pause is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | New atomic operation begins; sets the count back to 1 |
| att_ok | input | 1 | Attempt succeeded strobe |
| att_fail | input | 1 | Attempt failed strobe |
| pause_done | input | 1 | Pause unit reports the end of the pause |
| pause_req | output | 1 | One-cycle pause request |
| pause_amt | output | 20 | Pause length in cycles, held between requests |
| retry_permit | output | 1 | One-cycle permission to retry |

## Verification
Two functions can fall in the same cycle: the end of a pause (`pause_done`) and a new fail strobe. The bench provokes this by driving both strobes together while a pause is in progress. It then judges the result in the following cycle: `retry_permit` must pulse and `pause_req` must stay low. The next accepted failure must then carry only one doubling, not two. A second collision drives a success strobe together with a fail strobe. For that case the bench expects no request, followed by a base amount of 128.

// File: rtl/bo_pkg.sv
// Package: shared types for the retry backoff controller.
// Assumes: nothing beyond a two-state pause sequencer.
package bo_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } bo_state_e;
endpackage

// File: rtl/bo_counter.sv
// Module: bo_counter
// Holds the backoff count. It starts at 1, doubles on each advance, and
// saturates at CNT_MAX. A clear wins over an advance.
// Assumes: CNT_MAX >= 1; clear and advance are single-cycle strobes.
module bo_counter #(
    parameter int CNT_MAX = 4096,
    parameter int CNT_W   = $clog2(CNT_MAX) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W:0]   CEIL_WIDE = (CNT_W+1)'(CNT_MAX);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

    logic [CNT_W:0]   dbl;
    logic [CNT_W-1:0] nxt;

    // Doubled value, clipped at the ceiling.
    always_comb begin
        dbl = {cnt, 1'b0};
        nxt = (dbl > CEIL_WIDE) ? CNT_W'(CNT_MAX) : dbl[CNT_W-1:0];
    end

    // Count register: reset/clear to 1, otherwise double on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= ONE;
        end else if (clear) begin
            cnt <= ONE;
        end else if (advance) begin
            cnt <= nxt;
        end
    end
endmodule

// File: rtl/bo_scaler.sv
// Module: bo_scaler
// Latches the pause amount in cycles (count << SCALE_SHIFT) when a pause
// is started, and holds it until the next start.
// Assumes: AMT_W >= CNT_W + SCALE_SHIFT.
module bo_scaler #(
    parameter int CNT_W       = 13,
    parameter int SCALE_SHIFT = 7,
    parameter int AMT_W       = CNT_W + SCALE_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] cnt,
    output logic [AMT_W-1:0] amt
);
    logic [AMT_W-1:0] scaled;

    generate
        if (SCALE_SHIFT == 0) begin : g_unscaled
            // Amount equals the count directly.
            always_comb scaled = AMT_W'(cnt);
        end else begin : g_scaled
            // Amount is the count times 2**SCALE_SHIFT.
            always_comb scaled = AMT_W'(cnt) << SCALE_SHIFT;
        end
    endgenerate

    // Amount register: captured on load, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            amt <= '0;
        end else if (load) begin
            amt <= scaled;
        end
    end
endmodule

// File: rtl/bo_sequencer.sv
// Module: bo_sequencer
// Two-state pause sequencer. A start in IDLE issues a one-cycle pause
// request and enters WAIT. pause_done in WAIT returns to IDLE and gives
// a one-cycle retry permit.
// Assumes: start is only asserted when idle is high.
module bo_sequencer
    import bo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic pause_done,
    output logic idle,
    output logic pause_req,
    output logic retry_permit
);
    bo_state_e state;

    // Idle flag for the acceptance logic upstream.
    always_comb idle = (state == ST_IDLE);

    // State and single-cycle output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            pause_req    <= 1'b0;
            retry_permit <= 1'b0;
        end else begin
            pause_req    <= 1'b0;
            retry_permit <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state     <= ST_WAIT;
                        pause_req <= 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (pause_done) begin
                        state        <= ST_IDLE;
                        retry_permit <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/retry_backoff_ctrl.sv
// Module: retry_backoff_ctrl (top)
// Exponential backoff for retried atomic operations. A failed attempt in
// IDLE issues one pause request of (count << SCALE_SHIFT) cycles, then
// doubles the count up to CNT_MAX. A success or a new operation resets the
// count to 1. Fail strobes during a pause are ignored.
// Assumes: strobes are single-cycle and synchronous to clk.
module retry_backoff_ctrl #(
    parameter int CNT_MAX     = 4096,
    parameter int SCALE_SHIFT = 7,
    localparam int CNT_W      = $clog2(CNT_MAX) + 1,
    localparam int AMT_W      = CNT_W + SCALE_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_start,
    input  logic             att_ok,
    input  logic             att_fail,
    input  logic             pause_done,
    output logic             pause_req,
    output logic [AMT_W-1:0] pause_amt,
    output logic             retry_permit
);
    logic             clear;
    logic             accept;
    logic             idle;
    logic [CNT_W-1:0] cnt;

    // A reset of the count beats a failure; failures count only when idle.
    always_comb begin
        clear  = op_start | att_ok;
        accept = att_fail & idle & ~clear;
    end

    bo_counter #(
        .CNT_MAX (CNT_MAX),
        .CNT_W   (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .advance (accept),
        .cnt     (cnt)
    );

    bo_scaler #(
        .CNT_W       (CNT_W),
        .SCALE_SHIFT (SCALE_SHIFT),
        .AMT_W       (AMT_W)
    ) u_scl (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .cnt   (cnt),
        .amt   (pause_amt)
    );

    bo_sequencer u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (accept),
        .pause_done   (pause_done),
        .idle         (idle),
        .pause_req    (pause_req),
        .retry_permit (retry_permit)
    );
endmodule

// File: rtl/bo_checker.sv
// Module: bo_checker
// Port-level properties of retry_backoff_ctrl, attached through bind.
module bo_checker #(
    parameter int CNT_MAX     = 4096,
    parameter int SCALE_SHIFT = 7,
    parameter int AMT_W       = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_start,
    input logic             att_ok,
    input logic             att_fail,
    input logic             pause_done,
    input logic             pause_req,
    input logic [AMT_W-1:0] pause_amt,
    input logic             retry_permit
);
    localparam logic [AMT_W-1:0] AMT_CEIL = AMT_W'(CNT_MAX) << SCALE_SHIFT;

    // R2: request is a single-cycle pulse
    p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req |=> !pause_req);

    // R3: every requested amount is a power of two
    p_amt_pow2_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req |-> ($countones(pause_amt) == 1));

    // R4: never above the scaled ceiling
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req |-> (pause_amt <= AMT_CEIL));

    // R6: new operation suppresses a same-cycle failure
    p_start_no_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && att_fail) |=> !pause_req);

    // R7: a request and a permit never coincide
    p_req_permit_apart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(pause_req && retry_permit));

    // R8: permit is a single-cycle pulse that follows pause_done
    p_permit_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        retry_permit |=> !retry_permit);
    p_permit_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        retry_permit |-> $past(pause_done));

    // R9: amount holds outside request cycles
    p_amt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pause_req |-> $stable(pause_amt));

    // R10: success beats a same-cycle failure
    p_ok_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (att_ok && att_fail) |=> !pause_req);
endmodule

bind retry_backoff_ctrl bo_checker #(
    .CNT_MAX     (CNT_MAX),
    .SCALE_SHIFT (SCALE_SHIFT),
    .AMT_W       (AMT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_start     (op_start),
    .att_ok       (att_ok),
    .att_fail     (att_fail),
    .pause_done   (pause_done),
    .pause_req    (pause_req),
    .pause_amt    (pause_amt),
    .retry_permit (retry_permit)
);

// File: tb/tb_retry_backoff_ctrl.sv
`timescale 1ns/1ps
module tb_retry_backoff_ctrl;
    localparam int HALF = 4;   // 125 MHz
    localparam int AW   = 20;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          op_start, att_ok, att_fail, pause_done;
    logic          pause_req, retry_permit;
    logic [AW-1:0] pause_amt;

    int n_chk  = 0;
    int n_fail = 0;

    always #HALF clk = ~clk;

    retry_backoff_ctrl dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_start     (op_start),
        .att_ok       (att_ok),
        .att_fail     (att_fail),
        .pause_done   (pause_done),
        .pause_req    (pause_req),
        .pause_amt    (pause_amt),
        .retry_permit (retry_permit)
    );

    // Row kinds: 0 = failed attempt with full pause, 1 = success, 2 = new op
    typedef struct packed {
        logic [1:0]  kind;
        logic [31:0] amt;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{2'd0, 32'd128}, '{2'd0, 32'd256}, '{2'd0, 32'd512},
        '{2'd1, 32'd0},   '{2'd0, 32'd128}, '{2'd0, 32'd256},
        '{2'd2, 32'd0},   '{2'd0, 32'd128}, '{2'd0, 32'd256},
        '{2'd0, 32'd512}
    };

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive inputs for one cycle; returns at the next falling edge.
    task automatic step(input logic f, input logic o, input logic s, input logic d);
        att_fail = f; att_ok = o; op_start = s; pause_done = d;
        @(negedge clk);
        att_fail = 0; att_ok = 0; op_start = 0; pause_done = 0;
    endtask

    // Failed attempt, full pause, permit.
    task automatic fail_cycle(input int exp_amt, input string tag);
        step(1, 0, 0, 0);
        chk(pause_req == 1'b1, {tag, " R2 req"}, int'(pause_req), 1);
        chk(int'(pause_amt) == exp_amt, {tag, " amount"}, int'(pause_amt), exp_amt);
        step(0, 0, 0, 0);
        chk(pause_req == 1'b0, "R2 req pulse", int'(pause_req), 0);
        chk(int'(pause_amt) == exp_amt, "R9 amount held", int'(pause_amt), exp_amt);
        step(0, 0, 0, 1);
        chk(retry_permit == 1'b1, "R8 permit", int'(retry_permit), 1);
        step(0, 0, 0, 0);
        chk(retry_permit == 1'b0, "R8 permit pulse", int'(retry_permit), 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        att_fail = 0; att_ok = 0; op_start = 0; pause_done = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(2 * HALF * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk(pause_req == 1'b0, "R1 req", int'(pause_req), 0);
        chk(retry_permit == 1'b0, "R1 permit", int'(retry_permit), 0);
        chk(pause_amt == '0, "R1 amount", int'(pause_amt), 0);

        // Vector table (R1 first amount, R3 doubling, R5 success, R6 new op)
        for (int i = 0; i < 10; i++) begin
            case (VECS[i].kind)
                2'd0: fail_cycle(int'(VECS[i].amt), "R3 table");
                2'd1: step(0, 1, 0, 0);
                default: step(0, 0, 1, 0);
            endcase
        end

        // R4 saturation: 15 failures from a fresh count
        step(0, 0, 1, 0);
        for (int k = 0; k < 15; k++) begin
            fail_cycle((k < 12) ? (128 << k) : 524288, "R4 sat");
        end

        // R5 success after saturation
        step(0, 1, 0, 0);
        fail_cycle(128, "R5 after ok");

        // R7 fail during pause, then done together with a fail
        step(0, 0, 1, 0);
        step(1, 0, 0, 0);
        chk(int'(pause_amt) == 128, "R7 first amount", int'(pause_amt), 128);
        step(1, 0, 0, 0);
        chk(pause_req == 1'b0, "R7 fail in wait", int'(pause_req), 0);
        step(1, 0, 0, 1);
        chk(retry_permit == 1'b1, "R7 permit on collision", int'(retry_permit), 1);
        chk(pause_req == 1'b0, "R7 no req on collision", int'(pause_req), 0);
        step(0, 0, 0, 0);
        fail_cycle(256, "R7 single doubling");

        // R8 done while idle has no effect
        step(0, 0, 0, 1);
        chk(retry_permit == 1'b0, "R8 idle done", int'(retry_permit), 0);
        chk(pause_req == 1'b0, "R8 idle done req", int'(pause_req), 0);

        // R10 success and fail together
        step(1, 1, 0, 0);
        chk(pause_req == 1'b0, "R10 ok wins", int'(pause_req), 0);
        fail_cycle(128, "R10 after tie");

        // R6 new op and fail together
        fail_cycle(256, "R6 setup");
        step(1, 0, 1, 0);
        chk(pause_req == 1'b0, "R6 start wins", int'(pause_req), 0);
        fail_cycle(128, "R6 after start");

        // R1 reset in the middle of a pause
        step(1, 0, 0, 0);
        do_reset();
        chk(pause_req == 1'b0, "R1 mid reset req", int'(pause_req), 0);
        chk(pause_amt == '0, "R1 mid reset amount", int'(pause_amt), 0);
        step(0, 0, 0, 1);
        chk(retry_permit == 1'b0, "R1 mid reset idle", int'(retry_permit), 0);
        fail_cycle(128, "R1 after reset");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule